// File: doc/BRIEF.md
# Board Connectivity NAND Chain

This block is a board-level connectivity test structure for a device with a parallel bus interface. While the active-low reset pin is held low, every bus pad has its output driver switched off, so each pin acts purely as an input. The pin levels feed a serial chain of two-input NAND gates in a fixed order. The end of the chain replaces the core's interrupt request on the interrupt pad, and a board tester watches that pad.

The reset pin has two roles. It enables the test, and it is also the first input of the chain. A tester starts with reset low and every other chain pin high, and then pulls the pins low one at a time in chain order. The interrupt pad toggles at every step. A pin that is open or shorted on the board breaks that pattern at its own position in the order.

The chain begins with a NAND gate whose other input is tied high, so its first stage inverts reset. The bus pins come in pairs, which keeps the number of stages odd. As a result, the interrupt pad reads high both when only reset is low and when every chain input is low. A power-good input must be high for the test to take over the interrupt pad. When power-good is low, the interrupt pad keeps its normal open-drain behaviour.

Top module: `conn_nand_tree`

## Requirements
- R1: Test mode is active exactly when `rst_n` is 0 and `pwr_ok` is 1. In test mode `int_pad_oe` is 1 and `int_pad_o` carries the chain result, whatever the value of `core_irq_n`.
- R2: While `rst_n` is 0, every bit of `bus_pad_oe` is 0, whatever the values of `core_pad_oe` and `pwr_ok`.
- R3: While `rst_n` is 1, `bus_pad_oe` equals `core_pad_oe`. `bus_pad_o` always equals `core_pad_o`.
- R4: In test mode, with every chain input other than `rst_n` at 1, `int_pad_o` is 1.
- R5: In test mode, pulling the chain inputs low one at a time in chain order gives this sequence on `int_pad_o`:
  - it goes to 0 when `clk` is pulled low;
  - it goes back to 1 when `gnt_n` is also pulled low;
  - it toggles at every further step;
  - it reads 1 once every chain input is low.
- R6: In test mode, let j be the chain index of the last low input. `int_pad_o` is 1 when the number of chain inputs after j is even, and 0 when that number is odd. Low or high levels on inputs before j have no effect.
- R7: Outside test mode the interrupt pad is open-drain and active-low. `int_pad_o` is 0, and `int_pad_oe` is 1 exactly when `core_irq_n` is 0.
- R8: When `rst_n` is 0 and `pwr_ok` is 0, the interrupt pad follows R7 and the chain inputs have no effect on it.
- R9: The chain order is fixed:
  - index 0 is `rst_n`, index 1 is `clk` and index 2 is `gnt_n`;
  - index 3+m is `bus_pad_i[NB-1-m]`, so `bus_pad_i[0]` is the last input, at index NB+2;
  - NB = 2*PAIRS, so the chain always has an odd number of stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset; also enables test mode and is chain input 0 |
| pwr_ok | input | 1 | Power-good; must be 1 for the chain to drive the interrupt pad |
| clk | input | 1 | Bus clock pin level, chain input 1 |
| gnt_n | input | 1 | Bus grant pin level, chain input 2 |
| bus_pad_i | input | NB | Levels seen at the bidirectional and output bus pads |
| core_pad_o | input | NB | Core output data for the bus pads |
| core_pad_oe | input | NB | Core output enables for the bus pads |
| bus_pad_o | output | NB | Output data to the bus pads |
| bus_pad_oe | output | NB | Output enables to the bus pads |
| core_irq_n | input | 1 | Core interrupt request, active low |
| int_pad_o | output | 1 | Interrupt pad output data |
| int_pad_oe | output | 1 | Interrupt pad output enable |

## Verification
A walking-low sequence in chain order shows that each step toggles the pad, and that an open or misplaced tap breaks the alternation at its own index. Patterns with a single low pin are placed at the far ends of the bus range; they confirm that the bus bits are wired in descending order into the chain. Pseudo-random patterns with reset low, compared against the last-low-input parity rule, separate the real chain from one that merely counts the low pins. Runs with power-good low, and others with reset high, using varied core enables and interrupt levels, keep the pad-override path apart from the interrupt mux.

// File: rtl/conn_nand_tree.sv
`timescale 1ns/1ps
module conn_nand_tree #(
  parameter  int PAIRS = 5,
  localparam int NB    = 2 * PAIRS,
  localparam int NS    = NB + 3
) (
  input  logic          rst_n,
  input  logic          pwr_ok,
  input  logic          clk,
  input  logic          gnt_n,
  input  logic [NB-1:0] bus_pad_i,
  input  logic [NB-1:0] core_pad_o,
  input  logic [NB-1:0] core_pad_oe,
  output logic [NB-1:0] bus_pad_o,
  output logic [NB-1:0] bus_pad_oe,
  input  logic          core_irq_n,
  output logic          int_pad_o,
  output logic          int_pad_oe
);

  logic          tie_hi;
  logic          test_mode;
  logic [NS-1:0] tap;
  logic [NS-1:0] stg;

  assign tie_hi    = 1'b1;
  assign test_mode = ~rst_n & pwr_ok;

  // chain order (R9): reset, clock, grant, then bus bits from high index down to 0
  assign tap[0] = rst_n;
  assign tap[1] = clk;
  assign tap[2] = gnt_n;

  for (genvar m = 0; m < NB; m++) begin : g_tap
    assign tap[3+m] = bus_pad_i[NB-1-m];
  end

  assign stg[0] = ~(tie_hi & tap[0]);
  for (genvar k = 1; k < NS; k++) begin : g_stage
    assign stg[k] = ~(stg[k-1] & tap[k]);
  end

  assign bus_pad_o  = core_pad_o;
  assign bus_pad_oe = rst_n ? core_pad_oe : '0;

  assign int_pad_o  = test_mode ? stg[NS-1] : 1'b0;
  assign int_pad_oe = test_mode | ~core_irq_n;

  always_comb begin
    if (!rst_n) begin
      a_r2_pads_input: assert (bus_pad_oe == '0)
        else $error("R2: bus pad driver enabled during reset");
    end
    if (test_mode) begin
      a_r1_int_driven: assert (int_pad_oe)
        else $error("R1: interrupt pad not driven in test mode");
    end else begin
      a_r7_open_drain: assert (int_pad_o == 1'b0)
        else $error("R7: interrupt pad drives high outside test mode");
    end
    if (test_mode && (&tap[NS-1:1])) begin
      a_r4_start_high: assert (int_pad_o)
        else $error("R4: chain start state not high");
    end
    if (test_mode && !tap[1] && (&tap[NS-1:2])) begin
      a_r5_clk_step_low: assert (!int_pad_o)
        else $error("R5: clock step did not drive pad low");
    end
    if (test_mode && (tap == '0)) begin
      a_r5_all_low_high: assert (int_pad_o)
        else $error("R5: all-low state not high");
    end
  end

endmodule

// File: tb/conn_nand_tree_tb.sv
`timescale 1ns/1ps
module conn_nand_tree_tb;
  localparam int PAIRS = 5;
  localparam int NB    = 2 * PAIRS;
  localparam int NS    = NB + 3;

  typedef struct {
    string         tag;
    logic          o;
    logic          oe;
    logic [NB-1:0] po;
    logic [NB-1:0] poe;
  } exp_t;

  logic tb_clk = 1'b0;
  always #5 tb_clk = ~tb_clk;

  logic          rst_n = 1'b0, pwr_ok = 1'b0, bus_clk = 1'b1, gnt_n = 1'b1;
  logic [NB-1:0] bus_pad_i = '1, core_pad_o = '0, core_pad_oe = '0;
  logic [NB-1:0] bus_pad_o, bus_pad_oe;
  logic          core_irq_n = 1'b1;
  logic          int_pad_o, int_pad_oe;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  conn_nand_tree #(.PAIRS(PAIRS)) u_dut (
    .rst_n(rst_n), .pwr_ok(pwr_ok), .clk(bus_clk), .gnt_n(gnt_n),
    .bus_pad_i(bus_pad_i), .core_pad_o(core_pad_o), .core_pad_oe(core_pad_oe),
    .bus_pad_o(bus_pad_o), .bus_pad_oe(bus_pad_oe), .core_irq_n(core_irq_n),
    .int_pad_o(int_pad_o), .int_pad_oe(int_pad_oe)
  );

  // reference from R6: parity of inputs after the last low input
  function automatic logic ref_tree(logic [NS-1:0] p);
    int j = -1;
    for (int i = 0; i < NS; i++) if (!p[i]) j = i;
    if (j < 0) return 1'b0;
    return ((NS - 1 - j) % 2) == 0;
  endfunction

  task automatic drive(string tag, logic [NS-1:0] p, logic pg, logic irq_n,
                       logic [NB-1:0] c_o, logic [NB-1:0] c_oe);
    exp_t e;
    logic tm;
    @(posedge tb_clk);
    rst_n = p[0]; bus_clk = p[1]; gnt_n = p[2];
    for (int m = 0; m < NB; m++) bus_pad_i[NB-1-m] = p[3+m];
    pwr_ok = pg; core_irq_n = irq_n; core_pad_o = c_o; core_pad_oe = c_oe;
    tm    = !p[0] && pg;
    e.tag = tag;
    e.o   = tm ? ref_tree(p) : 1'b0;
    e.oe  = tm | !irq_n;
    e.po  = c_o;
    e.poe = p[0] ? c_oe : '0;
    q.push_back(e);
  endtask

  always @(negedge tb_clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int_pad_o !== e.o || int_pad_oe !== e.oe ||
          bus_pad_o !== e.po || bus_pad_oe !== e.poe) begin
        errors++;
        $display("FAIL %s: int_o=%b int_oe=%b pad_o=%h pad_oe=%h expected %b %b %h %h",
                 e.tag, int_pad_o, int_pad_oe, bus_pad_o, bus_pad_oe,
                 e.o, e.oe, e.po, e.poe);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] p;
    logic [31:0]   lfsr = 32'h1D3A_9C45;

    // reset state: R4 start pattern, R2 pads released
    p = '1; p[0] = 1'b0;
    drive("R4 reset start", p, 1'b1, 1'b1, 10'h15A, 10'h3FF);

    // R3 / R7 normal mode
    drive("R3 normal pads", '1, 1'b1, 1'b1, 10'h15A, 10'h2A5);
    drive("R7 irq asserted", '1, 1'b1, 1'b0, 10'h0F0, 10'h10F);
    drive("R7 irq released", '1, 1'b0, 1'b1, 10'h3C3, 10'h0F0);

    // R1: core interrupt ignored in test mode
    p = '1; p[0] = 1'b0;
    drive("R1 irq ignored", p, 1'b1, 1'b0, 10'h000, 10'h3FF);

    // R5 walking low in chain order
    p = '1; p[0] = 1'b0;
    for (int k = 1; k < NS; k++) begin
      p[k] = 1'b0;
      drive("R5 walk", p, 1'b1, 1'b1, 10'h055, 10'h3FF);
    end

    // R9 order: single low pins at both ends of the bus range
    p = '1; p[0] = 1'b0; p[NS-1] = 1'b0;
    drive("R9 last tap bit0", p, 1'b1, 1'b1, 10'h001, 10'h3FF);
    p = '1; p[0] = 1'b0; p[3] = 1'b0;
    drive("R9 first bus tap", p, 1'b1, 1'b1, 10'h200, 10'h3FF);
    p = '1; p[0] = 1'b0; p[2] = 1'b0;
    drive("R9 grant tap", p, 1'b1, 1'b1, 10'h200, 10'h3FF);

    // R6 arbitrary patterns
    for (int n = 0; n < 40; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      p = lfsr[NS-1:0]; p[0] = 1'b0;
      drive("R6 pattern", p, 1'b1, lfsr[20], lfsr[30:21], lfsr[31:22]);
    end

    // R8 power-good low with reset low
    for (int n = 0; n < 12; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      p = lfsr[NS-1:0]; p[0] = 1'b0;
      drive("R8 no power", p, 1'b0, n[0], lfsr[29:20], '1);
    end

    // R2 with reset high then low again
    drive("R3 release", '1, 1'b1, 1'b1, 10'h2AA, 10'h155);
    p = '0;
    drive("R2 all low", p, 1'b1, 1'b1, 10'h2AA, 10'h3FF);

    @(posedge tb_clk);
    @(posedge tb_clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule